// File: doc/BRIEF.md
# Per-Line Input Glitch and Debounce Filter

This block conditions the input levels of a bank of general-purpose I/O lines before software or logic reads them. Every raw line passes through a two-stage synchronizer. After that, each line can be left unfiltered or sent through its own filter. A per-line mode bit picks one of two timebases. The fast glitch mode samples on every enabled peripheral clock cycle. The debounce mode samples on the edges of a slow clock that is divided down by a programmable amount.

A filtered line changes its reported level only after the new level has been seen at two consecutive sample points of its timebase. The slow timebase is a single-cycle tick. It fires once every (DIV+1) slow-clock strobes, which places two ticks in each divided period of 2×(DIV+1) strobes. Writing DIV restarts that count. The mode bits are changed only through a pair of write-one masks, one that sets bits and one that clears them. The enable bits and DIV are written as whole words. A clock-enable input stands for the controller clock. While it is low, the synchronizer, the filters and the divider all hold their state, so the reported levels stay frozen.

Top module: `pin_filter_bank`

## Requirements
- R1: After reset, every mode bit reads 0, every filter is disabled and DIV is 0. Two enabled clock cycles after the pins settle, `pin_status` equals `pin_in`.
- R2: A 1 in `sel_set` sets the matching bit of `sel_status` on the next edge, and a 1 in `sel_clr` clears it. Where both masks carry a 1 for the same bit, the clear wins. Bits that are 0 in both masks keep their value.
- R3: With a line's filter disabled (`en` bit 0), `pin_status` for that line equals `pin_in` delayed by exactly two enabled clock cycles, pulses of any length included.
- R4: With the filter enabled and mode bit 0 (glitch mode), a pin level held for one clock cycle never reaches `pin_status`. A held level appears on `pin_status` exactly four clock cycles after it is driven.
- R5: The slow tick fires only in a cycle where `clk_en` and `slow_stb` are both high. It fires on every (DIV+1)-th such strobe. A DIV write reloads the strobe count with the new value.
- R6: With the filter enabled and mode bit 1 (debounce mode), a pulse shorter than DIV+1 strobes never reaches `pin_status`. A pulse lasting 2×(DIV+1) strobes always does.
- R7: Lines in glitch mode and lines in debounce mode filter at the same time and independently. A line's output depends only on its own pin, enable bit and mode bit.
- R8: While `clk_en` is low and no enable write occurs, `pin_status` holds its value whatever `pin_in` does.
- R9: An `en_we` pulse loads `en_wdata` as the new enable word, taking effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Controller clock enable; low freezes sampling and filters |
| slow_stb | input | 1 | One-cycle strobe per slow-clock period |
| pin_in | input | N_LINES | Raw line levels |
| sel_set | input | N_LINES | Write-one mask that sets mode bits |
| sel_clr | input | N_LINES | Write-one mask that clears mode bits |
| en_we | input | 1 | Load strobe for the enable word |
| en_wdata | input | N_LINES | New enable word |
| div_we | input | 1 | Load strobe for DIV; restarts the divider |
| div_wdata | input | DIV_W | New DIV value |
| sel_status | output | N_LINES | Current mode bits (0 glitch, 1 debounce) |
| pin_status | output | N_LINES | Conditioned line levels |

## Verification
A pin change takes two enabled edges to leave the synchronizer. An unfiltered line shows it at that point. A glitch-mode line shows it two edges later, four in total. A debounce-mode line shows it on the second tick after that. Mode-bit writes are visible one edge after the masks are driven. The bench drives every input just after the falling edge and samples at the next falling edge, after each rising edge in between has been applied. Its directed checks count edges to these exact points. Its random phase compares every cycle against a bench model that is advanced on the same rising edges.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic {
        MODE_GLITCH   = 1'b0,
        MODE_DEBOUNCE = 1'b1
    } pf_mode_e;
endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] lvl;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ce) begin
            st_d.meta = din;
            st_d.lvl  = st_q.meta;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.lvl;
endmodule

// File: rtl/pf_divider.sv
module pf_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             slow_stb,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t st_d, st_q;
    logic strobe;

    assign strobe = ce && slow_stb;
    assign tick   = strobe && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (div_we) begin
            st_d.div = div_wdata;
            st_d.cnt = div_wdata;
        end else if (strobe) begin
            if (st_q.cnt == '0) st_d.cnt = st_q.div;
            else                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pf_lane.sv
module pf_lane
    import pf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ce,
    input  logic     enable,
    input  pf_mode_e mode,
    input  logic     tick,
    input  logic     lvl,
    output logic     level_out
);
    typedef struct packed {
        logic out;
        logic pend;
    } lane_t;

    lane_t st_d, st_q;
    logic  sample;

    assign sample = ce && ((mode == MODE_DEBOUNCE) ? tick : 1'b1);

    always_comb begin
        st_d = st_q;
        if (ce && !enable) begin
            st_d.out  = lvl;
            st_d.pend = 1'b0;
        end else if (enable && sample) begin
            if (lvl != st_q.out) begin
                if (st_q.pend) begin
                    st_d.out  = lvl;
                    st_d.pend = 1'b0;
                end else begin
                    st_d.pend = 1'b1;
                end
            end else begin
                st_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_out = enable ? st_q.out : lvl;
endmodule

// File: rtl/pin_filter_bank.sv
module pin_filter_bank
    import pf_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_en,
    input  logic               slow_stb,
    input  logic [N_LINES-1:0] pin_in,
    input  logic [N_LINES-1:0] sel_set,
    input  logic [N_LINES-1:0] sel_clr,
    input  logic               en_we,
    input  logic [N_LINES-1:0] en_wdata,
    input  logic               div_we,
    input  logic [DIV_W-1:0]   div_wdata,
    output logic [N_LINES-1:0] sel_status,
    output logic [N_LINES-1:0] pin_status
);
    typedef struct packed {
        logic [N_LINES-1:0] sel;
        logic [N_LINES-1:0] en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [N_LINES-1:0] sync_lvl;
    logic               div_tick;

    always_comb begin
        cfg_d     = cfg_q;
        cfg_d.sel = (cfg_q.sel | sel_set) & ~sel_clr;
        if (en_we) cfg_d.en = en_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    pf_sync #(.W(N_LINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .ce   (clk_en),
        .din  (pin_in),
        .dout (sync_lvl)
    );

    pf_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (clk_en),
        .slow_stb (slow_stb),
        .div_we   (div_we),
        .div_wdata(div_wdata),
        .tick     (div_tick)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_lane
        pf_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .ce       (clk_en),
            .enable   (cfg_q.en[g]),
            .mode     (pf_mode_e'(cfg_q.sel[g])),
            .tick     (div_tick),
            .lvl      (sync_lvl[g]),
            .level_out(pin_status[g])
        );
    end

    assign sel_status = cfg_q.sel;
endmodule

// File: rtl/pin_filter_bank_chk.sv
module pin_filter_bank_chk #(
    parameter int N_LINES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clk_en,
    input logic               slow_stb,
    input logic               en_we,
    input logic               div_tick,
    input logic [N_LINES-1:0] sel_set,
    input logic [N_LINES-1:0] sel_clr,
    input logic [N_LINES-1:0] sel_status,
    input logic [N_LINES-1:0] pin_status
);
    AST_SEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_set & ~sel_clr) != '0) |=>
        ((sel_status & $past(sel_set & ~sel_clr)) == $past(sel_set & ~sel_clr))); // R2
    AST_SEL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_clr != '0) |=> ((sel_status & $past(sel_clr)) == '0)); // R2
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_set == '0 && sel_clr == '0) |=> $stable(sel_status)); // R2
    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !en_we) |=> $stable(pin_status)); // R8
    AST_TICK_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |-> (clk_en && slow_stb)); // R5
endmodule

bind pin_filter_bank pin_filter_bank_chk #(.N_LINES(N_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .slow_stb  (slow_stb),
    .en_we     (en_we),
    .div_tick  (div_tick),
    .sel_set   (sel_set),
    .sel_clr   (sel_clr),
    .sel_status(sel_status),
    .pin_status(pin_status)
);

// File: tb/tb_pin_filter_bank.sv
module tb_pin_filter_bank;
    localparam int N       = 8;
    localparam int DW      = 8;
    localparam int CLK_PER = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1;
    logic          slow_stb = 1'b0;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  sel_set = '0;
    logic [N-1:0]  sel_clr = '0;
    logic          en_we = 1'b0;
    logic [N-1:0]  en_wdata = '0;
    logic          div_we = 1'b0;
    logic [DW-1:0] div_wdata = '0;
    logic [N-1:0]  sel_status, pin_status;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    pin_filter_bank #(.N_LINES(N), .DIV_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .slow_stb(slow_stb),
        .pin_in(pin_in), .sel_set(sel_set), .sel_clr(sel_clr),
        .en_we(en_we), .en_wdata(en_wdata), .div_we(div_we),
        .div_wdata(div_wdata), .sel_status(sel_status), .pin_status(pin_status)
    );

    always #(CLK_PER/2) clk = ~clk;

    // Reference model built from the requirements, advanced on each rising edge
    logic [N-1:0]  m_s0, m_s1, m_out, m_pend, m_sel, m_en;
    logic [DW-1:0] m_cnt, m_div;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s0 = '0; m_s1 = '0; m_out = '0; m_pend = '0;
            m_sel = '0; m_en = '0; m_cnt = '0; m_div = '0;
        end else begin
            logic tk;
            tk = clk_en && slow_stb && (m_cnt == '0);       // R5
            for (int i = 0; i < N; i++) begin
                if (clk_en && !m_en[i]) begin
                    m_out[i] = m_s1[i]; m_pend[i] = 1'b0;
                end else if (clk_en && m_en[i] && (m_sel[i] ? tk : 1'b1)) begin
                    if (m_s1[i] != m_out[i]) begin
                        if (m_pend[i]) begin m_out[i] = m_s1[i]; m_pend[i] = 1'b0; end
                        else m_pend[i] = 1'b1;
                    end else m_pend[i] = 1'b0;
                end
            end
            if (clk_en) begin m_s1 = m_s0; m_s0 = pin_in; end
            if (div_we) begin m_div = div_wdata; m_cnt = div_wdata; end
            else if (clk_en && slow_stb) m_cnt = (m_cnt == '0) ? m_div : m_cnt - 1'b1;
            m_sel = (m_sel | sel_set) & ~sel_clr;
            if (en_we) m_en = en_wdata;
        end
    end

    function automatic logic [N-1:0] exp_status();
        return (m_en & m_out) | (~m_en & m_s1);
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic clear_writes();
        sel_set = '0; sel_clr = '0; en_we = 1'b0; div_we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic seen;
        void'($urandom(32'h5EED_1234));
        cyc(3);
        rst_n = 1'b1;
        // R1: reset state, raw path active
        check("R1 sel", sel_status, '0);
        pin_in = 8'hA5;
        cyc(2);
        check("R1 pass", pin_status, 8'hA5);

        // R3: unfiltered one-cycle pulse shows up two cycles later
        pin_in = 8'h00; cyc(3);
        pin_in = 8'h01; cyc(1); pin_in = 8'h00;
        cyc(1);
        check("R3 pulse", pin_status, 8'h01);
        cyc(1);
        check("R3 pulse end", pin_status, 8'h00);

        // R2: write-one set / clear, clear wins
        sel_set = 8'hF0; cyc(1); clear_writes();
        check("R2 set", sel_status, 8'hF0);
        sel_clr = 8'h30; sel_set = 8'h21; cyc(1); clear_writes();
        check("R2 clr wins", sel_status, 8'hC1);
        cyc(2);
        check("R2 hold", sel_status, 8'hC1);
        sel_clr = 8'hFF; cyc(1); clear_writes();
        check("R2 clr all", sel_status, 8'h00);

        // R9: enable word; lane0 glitch, lane1 debounce
        en_we = 1'b1; en_wdata = 8'h03; sel_set = 8'h02; cyc(1); clear_writes();
        check("R9 sel", sel_status, 8'h02);

        // R4: glitch mode
        pin_in = 8'h01; cyc(1); pin_in = 8'h00;
        seen = 1'b0;
        for (int k = 0; k < 6; k++) begin cyc(1); seen |= pin_status[0]; end
        check("R4 reject", {7'b0, seen}, 8'h00);
        pin_in = 8'h01;
        cyc(3);
        check("R4 not yet", pin_status & 8'h01, 8'h00);
        cyc(1);
        check("R4 accept", pin_status & 8'h01, 8'h01);
        pin_in = 8'h00; cyc(8);

        // R6: debounce, DIV=1, strobe every cycle
        slow_stb = 1'b1; div_we = 1'b1; div_wdata = 8'd1; cyc(1); clear_writes();
        cyc(6);
        pin_in = 8'h02; cyc(1); pin_in = 8'h00;
        seen = 1'b0;
        for (int k = 0; k < 12; k++) begin cyc(1); seen |= pin_status[1]; end
        check("R6 reject", {7'b0, seen}, 8'h00);
        pin_in = 8'h02; cyc(4); pin_in = 8'h00;
        seen = 1'b0;
        for (int k = 0; k < 12; k++) begin cyc(1); seen |= pin_status[1]; end
        check("R6 accept", {7'b0, seen}, 8'h01);
        cyc(12);

        // R7: both modes together, DIV=3
        div_we = 1'b1; div_wdata = 8'd3; cyc(1); clear_writes();
        pin_in = 8'h03; cyc(4);
        check("R7 glitch first", pin_status & 8'h03, 8'h01);
        cyc(10);
        check("R7 both", pin_status & 8'h03, 8'h03);

        // R8: gated clock freezes status
        clk_en = 1'b0; pin_in = 8'hFC; cyc(6);
        check("R8 frozen", pin_status, 8'h03);
        clk_en = 1'b1; cyc(2);
        check("R8 resume", pin_status & 8'hFC, 8'hFC);

        // Random phase against the model (R3 R4 R5 R6 R7 R8)
        slow_stb = 1'b0;
        for (int t = 0; t < 4000; t++) begin
            check("R7 random", pin_status, exp_status());
            check("R2 random", sel_status, m_sel);
            clear_writes();
            for (int i = 0; i < N; i++) if ($urandom_range(0, 9) == 0) pin_in[i] = ~pin_in[i];
            slow_stb = ($urandom_range(0, 2) == 0);
            clk_en   = ($urandom_range(0, 9) != 0);
            case ($urandom_range(0, 59))
                0: begin sel_set = N'($urandom); sel_clr = N'($urandom); end
                1: begin en_we = 1'b1; en_wdata = N'($urandom); end
                2: begin div_we = 1'b1; div_wdata = DW'($urandom_range(0, 4)); end
                default: ;
            endcase
            cyc(1);
        end
        check("R5 final", pin_status, exp_status());

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule